// File: doc/BRIEF.md
# Cyclic egress gate scheduler

The block opens and closes the eight traffic-class gates of up to four egress ports from a shared table of schedule entries. Each entry holds an 8-bit gate mask and an interval in nanoseconds. Each port owns a contiguous run of entries, given by a start index and an entry count. Once the synchronized nanosecond time reaches the programmed base time, the port runs its entries in order and returns to its first entry after the last. The cycle length of a port is therefore the sum of its intervals.

All gate events sit on a 200 ns slot grid. The base time and every interval must be whole multiples of 200 ns. No two ports may switch gates in the same slot. A schedule that breaks either rule is rejected: the error flag is raised and every gate stays open until the schedule is disabled. Software writes the entry table and the port ranges while the schedule is disabled, sets the base time, and then asserts the enable.

Top module: `gate_sched`

## Requirements
- R1: After reset, and in the cycle after any cycle with `sched_en` low, every bit of `gate_o` is 1 and `cfg_err_o` is 0.
- R2: While enabled but before `time_ns` reaches `base_time`, all gates are open. On the first clock edge that samples `time_ns >= base_time`, each port with a nonzero count shows the mask of its start entry.
- R3: In a mask, bit n set opens traffic class n. Port p drives `gate_o[8p+7:8p]`.
- R4: A port's first event falls at base time plus the interval of its start entry. Each later event falls at the previous event time plus the interval of the entry just entered. The new mask appears on the first clock edge that samples `time_ns` at or past the event time. Between events the mask does not change.
- R5: After the last entry of its range (start + count - 1), a port returns to its start entry.
- R6: A port whose entry count is 0 keeps all eight gates open while the others run.
- R7: If two running ports have equal pending event times (the same slot), `cfg_err_o` rises on the next edge and all gates open at that edge without the event being taken. Both stay so while `sched_en` is high.
- R8: At the would-be start, the schedule is rejected (`cfg_err_o` = 1, all gates open) if any of the following holds: the base time is not a multiple of 200; an entry in an active port's range has a zero interval, an interval that is not a multiple of 200, or was never written since reset; or start + count exceeds the table depth.
- R9: Entry writes and port-range writes made while `sched_en` is high have no effect.
- R10: Lowering `sched_en` clears the error. The next start restarts every port at its start entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_ns | input | 64 | Synchronized time in nanoseconds |
| sched_en | input | 1 | Schedule enable; configuration writes are accepted only while low |
| base_time | input | 64 | Absolute start time in nanoseconds |
| ent_we | input | 1 | Entry table write strobe |
| ent_addr | input | 4 | Entry index |
| ent_mask | input | 8 | Gate mask for the entry |
| ent_ivl | input | 32 | Interval for the entry in nanoseconds |
| prt_we | input | 1 | Port range write strobe |
| prt_addr | input | 2 | Port being configured |
| prt_start | input | 4 | First entry of the port |
| prt_count | input | 5 | Number of entries of the port (0 = idle) |
| gate_o | output | 32 | Gate masks, 8 bits per port, port 0 in the low byte |
| cfg_err_o | output | 1 | Schedule rejected |

## Verification
In one cycle a port can be due to take its next event while the cross-port comparison finds that same pending event time on another port. The design must then reject the schedule instead of advancing. The bench provokes this with a second port whose 300 us entries do not collide with the first port's 100/400 us cycle until the first port's second cycle. So the run first passes through several clean events on both ports, and the collision then becomes pending. The judgment is that the error rises, with every gate open, one edge after the equal event times are registered and before the shared event time is reached. The start-time rule checks in R8 and the launch decision likewise share a cycle; each bad configuration is checked to give an error with no start mask ever shown.

// File: rtl/gate_sched_pkg.sv
package gate_sched_pkg;
    localparam int unsigned TC_COUNT = 8;
    localparam int unsigned TIME_W   = 64;
    localparam int unsigned IVL_W    = 32;
    localparam int unsigned SLOT_NS  = 200;

    typedef logic [TC_COUNT-1:0] gmask_t;
    typedef logic [TIME_W-1:0]   tstamp_t;
    typedef logic [IVL_W-1:0]    ivl_t;
endpackage

// File: rtl/gate_entry_table.sv
module gate_entry_table
    import gate_sched_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_i,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  gmask_t               mask_i,
    input  ivl_t                 ivl_i,
    output gmask_t [DEPTH-1:0]   masks_o,
    output ivl_t   [DEPTH-1:0]   ivls_o,
    output logic   [DEPTH-1:0]   bad_o
);
    typedef struct packed {
        gmask_t [DEPTH-1:0] mask;
        ivl_t   [DEPTH-1:0] ivl;
        logic   [DEPTH-1:0] bad;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && !lock_i) begin
            st_d.mask[addr_i] = mask_i;
            st_d.ivl[addr_i]  = ivl_i;
            // an interval must be nonzero and lie on the slot grid
            st_d.bad[addr_i]  = (ivl_i == '0) || ((ivl_i % IVL_W'(SLOT_NS)) != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '0;
            st_q.ivl  <= '0;
            st_q.bad  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign masks_o = st_q.mask;
    assign ivls_o  = st_q.ivl;
    assign bad_o   = st_q.bad;

    // writes while the schedule runs must not alter the table
    assert_write_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && lock_i) |=> $stable(st_q));
endmodule

// File: rtl/gate_port_engine.sv
module gate_port_engine
    import gate_sched_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  tstamp_t              time_ns_i,
    input  tstamp_t              base_time_i,
    input  logic                 launch_i,
    input  logic                 halt_i,
    input  logic [AW-1:0]        start_i,
    input  logic [CW-1:0]        count_i,
    input  gmask_t [DEPTH-1:0]   masks_i,
    input  ivl_t   [DEPTH-1:0]   ivls_i,
    output gmask_t               gate_o,
    output logic                 active_o,
    output tstamp_t              next_evt_o
);
    typedef struct packed {
        logic          active;
        logic [AW-1:0] cur;
        tstamp_t       next;
        gmask_t        gate;
    } eng_t;

    eng_t          st_d, st_q;
    logic [AW-1:0] last_idx;
    logic [AW-1:0] nidx;
    logic          due;

    assign last_idx = start_i + AW'(count_i - CW'(1));
    assign nidx     = (st_q.cur == last_idx) ? start_i : st_q.cur + AW'(1);
    assign due      = st_q.active && (time_ns_i >= st_q.next);

    always_comb begin
        st_d = st_q;
        if (halt_i) begin
            st_d.active = 1'b0;
            st_d.gate   = '1;
        end else if (launch_i) begin
            if (count_i != '0) begin
                st_d.active = 1'b1;
                st_d.cur    = start_i;
                st_d.next   = base_time_i + TIME_W'(ivls_i[start_i]);
                st_d.gate   = masks_i[start_i];
            end else begin
                st_d.active = 1'b0;
                st_d.gate   = '1;
            end
        end else if (due) begin
            st_d.cur  = nidx;
            st_d.next = st_q.next + TIME_W'(ivls_i[nidx]);
            st_d.gate = masks_i[nidx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.cur    <= '0;
            st_q.next   <= '0;
            st_q.gate   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o     = st_q.gate;
    assign active_o   = st_q.active;
    assign next_evt_o = st_q.next;

    // no mask change while the pending event lies in the future
    assert_hold_between_events_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !halt_i && !launch_i && time_ns_i < st_q.next) |=> $stable(st_q.gate));

    // stepping past the end of the range lands on the start entry
    assert_wrap_to_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !halt_i && !launch_i && st_q.cur == last_idx) |=> (st_q.cur == $past(start_i)));
endmodule

// File: rtl/gate_sched.sv
module gate_sched
    import gate_sched_pkg::*;
#(
    parameter int unsigned PORTS = 4,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned EW   = CW + 1,
    localparam int unsigned PW   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TIME_W-1:0]         time_ns,
    input  logic                      sched_en,
    input  logic [TIME_W-1:0]         base_time,
    input  logic                      ent_we,
    input  logic [AW-1:0]             ent_addr,
    input  logic [TC_COUNT-1:0]       ent_mask,
    input  logic [IVL_W-1:0]          ent_ivl,
    input  logic                      prt_we,
    input  logic [PW-1:0]             prt_addr,
    input  logic [AW-1:0]             prt_start,
    input  logic [CW-1:0]             prt_count,
    output logic [PORTS*TC_COUNT-1:0] gate_o,
    output logic                      cfg_err_o
);
    typedef struct packed {
        logic                       started;
        logic                       err;
        logic [PORTS-1:0][AW-1:0]   pstart;
        logic [PORTS-1:0][CW-1:0]   pcount;
    } top_t;

    top_t st_d, st_q;

    gmask_t [DEPTH-1:0]  tbl_mask;
    ivl_t   [DEPTH-1:0]  tbl_ivl;
    logic   [DEPTH-1:0]  tbl_bad;

    gmask_t  [PORTS-1:0] eng_gate;
    logic    [PORTS-1:0] eng_act;
    tstamp_t [PORTS-1:0] eng_next;

    logic [EW-1:0] end_v [PORTS];
    logic          cfg_bad;
    logic          conflict;
    logic          launch_req;
    logic          launch;
    logic          halt;

    gate_entry_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (sched_en),
        .we_i    (ent_we),
        .addr_i  (ent_addr),
        .mask_i  (ent_mask),
        .ivl_i   (ent_ivl),
        .masks_o (tbl_mask),
        .ivls_o  (tbl_ivl),
        .bad_o   (tbl_bad)
    );

    // static rule check of base time and every active range
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            end_v[p] = EW'(st_q.pstart[p]) + EW'(st_q.pcount[p]);
        end
    end

    always_comb begin
        cfg_bad = (base_time % TIME_W'(SLOT_NS)) != '0;
        for (int p = 0; p < PORTS; p++) begin
            if (st_q.pcount[p] != '0) begin
                if (end_v[p] > EW'(DEPTH)) cfg_bad = 1'b1;
                for (int e = 0; e < DEPTH; e++) begin
                    if (EW'(e) >= EW'(st_q.pstart[p]) && EW'(e) < end_v[p] && tbl_bad[e])
                        cfg_bad = 1'b1;
                end
            end
        end
    end

    // two running ports pending on the same slot
    always_comb begin
        conflict = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            for (int q = p + 1; q < PORTS; q++) begin
                if (eng_act[p] && eng_act[q] && eng_next[p] == eng_next[q])
                    conflict = 1'b1;
            end
        end
    end

    assign launch_req = sched_en && !st_q.started && !st_q.err && (time_ns >= base_time);
    assign launch     = launch_req && !cfg_bad;
    assign halt       = !sched_en || st_q.err || conflict;

    always_comb begin
        st_d = st_q;
        if (prt_we && !sched_en) begin
            st_d.pstart[prt_addr] = prt_start;
            st_d.pcount[prt_addr] = prt_count;
        end
        if (!sched_en) begin
            st_d.started = 1'b0;
            st_d.err     = 1'b0;
        end else begin
            if (launch_req) st_d.started = 1'b1;
            if ((launch_req && cfg_bad) || conflict) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
        gate_port_engine #(.DEPTH(DEPTH)) u_eng (
            .clk         (clk),
            .rst_n       (rst_n),
            .time_ns_i   (time_ns),
            .base_time_i (base_time),
            .launch_i    (launch),
            .halt_i      (halt),
            .start_i     (st_q.pstart[gp]),
            .count_i     (st_q.pcount[gp]),
            .masks_i     (tbl_mask),
            .ivls_i      (tbl_ivl),
            .gate_o      (eng_gate[gp]),
            .active_o    (eng_act[gp]),
            .next_evt_o  (eng_next[gp])
        );
    end

    assign gate_o    = eng_gate;
    assign cfg_err_o = st_q.err;

    assert_idle_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_en |=> (gate_o == '1 && !cfg_err_o));

    assert_conflict_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_en && conflict) |=> cfg_err_o);

    assert_err_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (gate_o == '1));

    assert_err_no_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && cfg_bad) |=> (gate_o == '1));
endmodule

// File: tb/gate_sched_tb_top.sv
module gate_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_ns = '0;
    logic        sched_en = 1'b0;
    logic [63:0] base_time = 64'd1_000_000;
    logic        ent_we = 1'b0;
    logic [3:0]  ent_addr = '0;
    logic [7:0]  ent_mask = '0;
    logic [31:0] ent_ivl = '0;
    logic        prt_we = 1'b0;
    logic [1:0]  prt_addr = '0;
    logic [3:0]  prt_start = '0;
    logic [4:0]  prt_count = '0;
    logic [31:0] gate_o;
    logic        cfg_err_o;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] BASE = 64'd1_000_000;

    always #5 clk = ~clk;

    gate_sched dut_i (
        .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .sched_en(sched_en),
        .base_time(base_time), .ent_we(ent_we), .ent_addr(ent_addr),
        .ent_mask(ent_mask), .ent_ivl(ent_ivl), .prt_we(prt_we),
        .prt_addr(prt_addr), .prt_start(prt_start), .prt_count(prt_count),
        .gate_o(gate_o), .cfg_err_o(cfg_err_o)
    );

    typedef struct packed {
        logic [63:0] t;
        logic [7:0]  g0;
    } vec_t;

    // port 0 runs class 7 for 100 us then classes 0-6 for 400 us (R2, R4, R5)
    localparam vec_t VECS [8] = '{
        '{64'd999_800,   8'hFF},
        '{64'd1_000_000, 8'h80},
        '{64'd1_099_800, 8'h80},
        '{64'd1_100_000, 8'h7F},
        '{64'd1_499_800, 8'h7F},
        '{64'd1_500_000, 8'h80},
        '{64'd1_600_000, 8'h7F},
        '{64'd2_000_000, 8'h80}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [63:0] t);
        @(negedge clk);
        time_ns = t;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_entry(input int a, input logic [7:0] m, input logic [31:0] iv);
        @(negedge clk);
        ent_we = 1'b1; ent_addr = 4'(a); ent_mask = m; ent_ivl = iv;
        @(posedge clk);
        #1;
        ent_we = 1'b0;
    endtask

    task automatic wr_port(input int p, input int s, input int c);
        @(negedge clk);
        prt_we = 1'b1; prt_addr = 2'(p); prt_start = 4'(s); prt_count = 5'(c);
        @(posedge clk);
        #1;
        prt_we = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        sched_en = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset gates", 64'(gate_o), 64'hFFFF_FFFF);
        check("R1 reset err", 64'(cfg_err_o), 64'd0);
        rst_n = 1'b1;
        step(0);
        check("R1 idle gates", 64'(gate_o), 64'hFFFF_FFFF);

        wr_entry(0, 8'h80, 32'd100_000);
        wr_entry(1, 8'h7F, 32'd400_000);
        wr_entry(2, 8'h0F, 32'd300_000);
        wr_entry(3, 8'h30, 32'd300_000);
        wr_port(0, 0, 2);
        set_en(1'b1);

        // walk the vector table; port 1 idle checks R6
        for (int i = 0; i < 8; i++) begin
            step(VECS[i].t);
            check("R2/R4/R5 port0 mask", 64'(gate_o[7:0]), 64'(VECS[i].g0));
            check("R6 idle port1", 64'(gate_o[15:8]), 64'hFF);
            check("R4 no error", 64'(cfg_err_o), 64'd0);
        end

        // R9: writes while running are dropped
        wr_entry(1, 8'h01, 32'd200);
        wr_port(1, 2, 1);
        step(64'd2_100_000);
        check("R9 entry write ignored", 64'(gate_o[7:0]), 64'h7F);
        check("R9 port write ignored", 64'(gate_o[15:8]), 64'hFF);

        set_en(1'b0);
        step(64'd2_100_200);
        check("R1 disabled gates", 64'(gate_o), 64'hFFFF_FFFF);

        // two ports: clean events, then collision on a shared slot (R3, R7)
        wr_port(1, 2, 2);
        set_en(1'b1);
        step(BASE);
        check("R3 bus layout", 64'(gate_o), 64'hFFFF_0F80);
        step(BASE + 64'd100_000);
        check("R4 port0 second entry", 64'(gate_o[15:0]), 64'h0F7F);
        step(BASE + 64'd300_000);
        check("R4 port1 second entry", 64'(gate_o[15:0]), 64'h307F);
        check("R7 no early error", 64'(cfg_err_o), 64'd0);
        step(BASE + 64'd500_000);
        check("R5 port0 wrap", 64'(gate_o[15:0]), 64'h3080);
        check("R7 no error yet", 64'(cfg_err_o), 64'd0);
        step(BASE + 64'd500_200);
        check("R7 conflict flagged", 64'(cfg_err_o), 64'd1);
        check("R7 gates open", 64'(gate_o), 64'hFFFF_FFFF);
        step(BASE + 64'd600_000);
        check("R7 error held", 64'(cfg_err_o), 64'd1);
        check("R7 gates held open", 64'(gate_o), 64'hFFFF_FFFF);

        // R10: disable clears, restart from start entry
        set_en(1'b0);
        step(0);
        check("R10 error cleared", 64'(cfg_err_o), 64'd0);
        wr_port(1, 0, 0);
        set_en(1'b1);
        step(BASE + 64'd200);
        check("R10 restart at start entry", 64'(gate_o[7:0]), 64'h80);
        check("R10 clean restart", 64'(cfg_err_o), 64'd0);

        // R8: rejected configurations
        set_en(1'b0);
        wr_entry(5, 8'h11, 32'd0);
        wr_port(1, 5, 1);
        set_en(1'b1);
        step(BASE);
        check("R8 zero interval err", 64'(cfg_err_o), 64'd1);
        check("R8 zero interval gates", 64'(gate_o), 64'hFFFF_FFFF);

        set_en(1'b0);
        wr_entry(5, 8'h11, 32'd150);
        set_en(1'b1);
        step(BASE);
        check("R8 off-grid interval err", 64'(cfg_err_o), 64'd1);

        set_en(1'b0);
        wr_port(1, 0, 0);
        @(negedge clk);
        base_time = BASE + 64'd100;
        set_en(1'b1);
        step(BASE + 64'd200);
        check("R8 off-grid base err", 64'(cfg_err_o), 64'd1);
        check("R8 off-grid base gates", 64'(gate_o), 64'hFFFF_FFFF);

        set_en(1'b0);
        @(negedge clk);
        base_time = BASE;
        wr_entry(15, 8'h22, 32'd200_000);
        wr_port(1, 15, 2);
        set_en(1'b1);
        step(BASE);
        check("R8 range overflow err", 64'(cfg_err_o), 64'd1);

        set_en(1'b0);
        wr_port(1, 7, 1);
        set_en(1'b1);
        step(BASE);
        check("R8 unwritten entry err", 64'(cfg_err_o), 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule